// File: doc/BRIEF.md
# Per-Bit Latch Serial Byte Receiver

This block receives one asynchronous serial character made of a low start bit, eight data bits sent least significant bit first, and a high stop bit. It presents the character as a parallel byte. There is no shift register. Each data bit has its own holding latch, and all eight latches watch the same synchronised serial line. While a latch is open, its output bit follows the line. A bit-slot timer closes the latches one at a time, each at the middle of its own data slot. When the eighth latch closes, the whole byte is held on the output bus.

A falling edge on the idle line sets a run flag, which starts the slot timer. At the same moment every latch is opened again. The timer issues eight capture strobes, spaced one bit period apart. The last strobe clears the run flag and raises a one-cycle done pulse. After that, no new start edge is accepted until the line has been seen high. The bit period is a whole number of clock cycles, set by a parameter. Parity, stop-bit checking and buffering are left to the logic around the block.

Top module: `ser_latch_rx`

## Requirements
- R1: After a synchronous active-high reset, busy and done are low and all eight latches are open, so with the line held high the data bus reads 8'hFF within four clocks of reset release.
- R2: A high-to-low transition of the synchronised line while idle and re-armed raises busy. With the line changed between clock edges, busy is low after the second following rising edge and high after the third.
- R3: The timer produces exactly eight capture strobes, at most one per cycle. Strobe k (k = 0..7) captures the synchronised line at (k + 1.5) bit periods after the start is detected.
- R4: Data bit k of the bus holds the value of serial data bit k, where the first bit after the start bit is bit 0 and the eighth is bit 7.
- R5: A bit whose strobe has not yet occurred follows the live serial line, delayed by the synchroniser and one register.
- R6: A bit whose strobe has occurred keeps its value until the next accepted start, whatever the line does.
- R7: Falling edges on the line during a frame do not restart or extend the timer.
- R8: An accepted start reopens all eight latches, so during the start bit the whole bus follows the low line and reads 8'h00.
- R9: After a frame completes, no start is accepted until the synchronised line has been high at least once while idle. A line held low straight after the eighth bit leaves busy low.
- R10: Done is a single-cycle pulse. It rises on the same rising edge at which busy falls and bit 7 is locked: the (3 + 8.5 x bit period)-th edge after the line falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Parallel byte, one latch per bit |
| rx_busy | output | 1 | Run flag: timer active |
| rx_done | output | 1 | One-cycle pulse when bit 7 is locked |

## Verification
The hardest state to reach from the ports is a partly locked byte. In that state the lower bits are held while the upper bits still track the wire, and the only way to see it is to sample at an exact cycle inside a frame. The bench drives every frame cycle by cycle from a counter that starts at the falling edge. A few cycles into each data slot, it compares the whole bus against a mixed value computed from the byte being sent. A second corner is a frame whose last data bit is low and which has no stop bit, with the line then held low. This shows that the end of the frame does not re-arm the receiver, and that the locked byte survives a line stuck low.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int NUM_BITS = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_flag_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], line_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.chain <= '1;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.chain[STAGES-1];
    assign fall_o = st_q.prev & ~st_q.chain[STAGES-1];

    a_r2_fall_needs_prior_high: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> $past(line_o));
endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer
    import rx_pkg::*;
#(
    parameter int CPB   = 16,
    parameter int NBITS = NUM_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             fall_i,
    output logic             busy_o,
    output logic             arm_o,
    output logic             done_o,
    output logic [NBITS-1:0] strobe_o
);
    localparam int FIRST = CPB + CPB / 2 - 1;
    localparam int SLOT  = CPB - 1;
    localparam int CW    = $clog2(FIRST + 1);
    localparam int IW    = (NBITS > 1) ? $clog2(NBITS) : 1;

    typedef struct packed {
        run_flag_e       flag;
        logic [CW-1:0]   down;
        logic [IW-1:0]   idx;
        logic            rearm;
        logic            done;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    fire;
    logic    last_slot;

    assign fire      = (st_q.flag == ST_RUN) && (st_q.down == '0);
    assign last_slot = (st_q.idx == IW'(NBITS - 1));

    for (genvar g = 0; g < NBITS; g++) begin : g_strobe
        assign strobe_o[g] = fire && (st_q.idx == IW'(g));
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        arm_o     = 1'b0;
        if (st_q.flag == ST_IDLE) begin
            if (line_i) begin
                st_d.rearm = 1'b1;
            end
            if (fall_i && st_q.rearm) begin
                st_d.flag = ST_RUN;
                st_d.down = CW'(FIRST);
                st_d.idx  = '0;
                arm_o     = 1'b1;
            end
        end else if (fire) begin
            if (last_slot) begin
                st_d.flag  = ST_IDLE;
                st_d.done  = 1'b1;
                st_d.rearm = 1'b0;
            end else begin
                st_d.idx  = st_q.idx + 1'b1;
                st_d.down = CW'(SLOT);
            end
        end else begin
            st_d.down = st_q.down - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flag  <= ST_IDLE;
            st_q.down  <= '0;
            st_q.idx   <= '0;
            st_q.rearm <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.flag == ST_RUN);
    assign done_o = st_q.done;

    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));
    a_r3_strobe_in_run: assert property (@(posedge clk) disable iff (rst)
        (|strobe_o) |-> busy_o);
    a_r3_last_strobe_ends: assert property (@(posedge clk) disable iff (rst)
        strobe_o[NBITS-1] |=> (done_o && !busy_o));
    a_r7_no_arm_in_run: assert property (@(posedge clk) disable iff (rst)
        arm_o |-> !busy_o);
    a_r2_arm_sets_busy: assert property (@(posedge clk) disable iff (rst)
        arm_o |=> busy_o);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: rtl/rx_bit_latches.sv
module rx_bit_latches #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             reopen_i,
    input  logic [NBITS-1:0] strobe_i,
    output logic [NBITS-1:0] data_o
);
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        typedef struct packed {
            logic open;
            logic val;
        } bit_t;

        bit_t b_d, b_q;

        always_comb begin
            b_d     = b_q;
            b_d.val = b_q.open ? line_i : b_q.val;
            if (reopen_i) begin
                b_d.open = 1'b1;
            end else if (strobe_i[g]) begin
                b_d.open = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                b_q.open <= 1'b1;
                b_q.val  <= 1'b0;
            end else begin
                b_q <= b_d;
            end
        end

        assign data_o[g] = b_q.val;

        a_r6_closed_holds: assert property (@(posedge clk) disable iff (rst)
            (!b_q.open && !reopen_i) |=> $stable(data_o[g]));
        a_r5_open_follows: assert property (@(posedge clk) disable iff (rst)
            b_q.open |=> (data_o[g] == $past(line_i)));
    end
endmodule

// File: rtl/ser_latch_rx.sv
module ser_latch_rx
    import rx_pkg::*;
#(
    parameter int CPB         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_line,
    output logic [NUM_BITS-1:0] rx_data,
    output logic                rx_busy,
    output logic                rx_done
);
    logic                line_s;
    logic                fall_s;
    logic                arm;
    logic [NUM_BITS-1:0] strobe;

    rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (rx_line),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    rx_slot_timer #(.CPB(CPB), .NBITS(NUM_BITS)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .line_i   (line_s),
        .fall_i   (fall_s),
        .busy_o   (rx_busy),
        .arm_o    (arm),
        .done_o   (rx_done),
        .strobe_o (strobe)
    );

    rx_bit_latches #(.NBITS(NUM_BITS)) latch_i (
        .clk      (clk),
        .rst      (rst),
        .line_i   (line_s),
        .reopen_i (arm),
        .strobe_i (strobe),
        .data_o   (rx_data)
    );

    a_r8_arm_on_fall: assert property (@(posedge clk) disable iff (rst)
        arm |-> fall_s);
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(strobe[NUM_BITS-1]));
endmodule

// File: tb/ser_latch_rx_tb_top.sv
module ser_latch_rx_tb_top;
    localparam int CPB    = 16;
    localparam int HALF   = CPB / 2;
    localparam int N_DONE = 3 + 8 * CPB + HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_busy;
    logic       rx_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ser_latch_rx #(.CPB(CPB)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .rx_line (rx_line),
        .rx_data (rx_data),
        .rx_busy (rx_busy),
        .rx_done (rx_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Bits below j are locked, bits j and above follow the current data bit j.
    function automatic logic [7:0] mid_frame(input logic [7:0] b, input int j);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (i < j) ? b[i] : b[j];
        return r;
    endfunction

    task automatic send_frame(input logic [7:0] b, input bit with_stop);
        int done_seen = 0;
        for (int n = 0; n < 10 * CPB; n++) begin
            @(negedge clk);
            if (n == 2) check(rx_busy == 1'b0, "R2 busy before start", rx_busy, 0);
            if (n == 3) check(rx_busy == 1'b1, "R2 busy on start", rx_busy, 1);
            if (n == 5) check(rx_data == 8'h00, "R8 reopen during start", rx_data, 8'h00);
            if (n >= CPB && n < 9 * CPB && (n % CPB) == 5)
                check(rx_data == mid_frame(b, n / CPB - 1), "R5 partial lock",
                      rx_data, mid_frame(b, n / CPB - 1));
            if (n == N_DONE - 1)
                check(rx_busy && !rx_done, "R7 busy until last strobe", {rx_busy, rx_done}, 2);
            if (n == N_DONE) begin
                check(rx_done && !rx_busy, "R10 done edge", {rx_busy, rx_done}, 1);
                check(rx_data == b, "R4 byte captured", rx_data, b);
            end
            if (n == N_DONE + 1) check(rx_done == 1'b0, "R10 done one cycle", rx_done, 0);
            if (n > 3 && rx_done) done_seen++;
            if (n == 0) rx_line = 1'b0;
            else if (n < 9 * CPB && (n % CPB) == 0) rx_line = b[n / CPB - 1];
            else if (n == 9 * CPB) rx_line = with_stop;
        end
        @(negedge clk);
        check(done_seen == 1, "R3 one completion per frame", done_seen, 1);
        check(rx_data == b, "R6 locked after stop", rx_data, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] dir [6] = '{8'hFF, 8'h00, 8'h55, 8'hA5, 8'h80, 8'h01};
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        check(rx_busy == 1'b0 && rx_done == 1'b0, "R1 reset outputs", {rx_busy, rx_done}, 0);
        rst = 1'b0;
        check(rx_busy == 1'b0 && rx_done == 1'b0, "R1 after release", {rx_busy, rx_done}, 0);
        repeat (4) @(negedge clk);
        check(rx_data == 8'hFF, "R1 latches open", rx_data, 8'hFF);
        for (int i = 0; i < 6; i++) begin
            send_frame(dir[i], 1'b1);
            repeat (2) @(negedge clk);
        end
        // Break: last data bit low, no stop bit, line held low.
        send_frame(8'h3C, 1'b0);
        for (int n = 0; n < 3 * CPB; n++) begin
            @(negedge clk);
            if (rx_busy) break;
        end
        check(rx_busy == 1'b0, "R9 no start while held low", rx_busy, 0);
        check(rx_data == 8'h3C, "R6 held through break", rx_data, 8'h3C);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
        send_frame(8'hC3, 1'b1);
        for (int i = 0; i < 20; i++) begin
            send_frame(8'($urandom), 1'b1);
            repeat (1 + ($urandom % 5)) @(negedge clk);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule